// File: doc/BRIEF.md
# Shared IRQ Flag Controller

This block keeps a small bank of event flags that a group of sequencer state machines share. Each machine presents the instruction it is executing. The block acts on two kinds of instruction. The first raises or clears a flag, and can optionally hold the machine until the flag drops again. The second makes the machine wait until a chosen flag reaches a given level. The controller computes the per-machine stall, and it applies every set and clear in one registered update.

A flag index can be absolute. It can also be relative, in which case the low bits of the index are rotated by the requesting machine's number inside its group of four. One program can then run on every machine and still use a separate flag per machine. A host port reads the flags and clears them with write-one-to-clear pulses. Two interrupt lines each combine the lower four flags with per-machine FIFO status inputs through their own enable mask.

Top module: `irq_flag_ctrl`

## Requirements
- R1: While rst_ni is low and after its release, flags_o is zero, every exec_stall_o bit is low, and irq_o is zero when tx_not_full_i and rx_not_empty_i are zero.
- R2: A flag instruction has bits [15:13] = 3'b110, bit 6 = clear, bit 5 = wait, bit 4 = relative, and bits [2:0] = index. A valid raise sets its flag from the next clock edge onward. An instruction with any other opcode, or one whose exec_valid_i bit is low, changes no flag.
- R3: For a relative index idx issued by machine m, the target flag is (idx & 4) | ((idx + m) & 3). Without the relative bit, the target flag is idx itself.
- R4: A flag instruction with the clear bit set drops its target flag at the next edge and never stalls the machine.
- R5: A raise with the wait bit set stalls the machine in its issue cycle. After that, the machine stays stalled for as long as the target flag reads one. The stall is released in the first cycle the flag reads zero.
- R6: A wait instruction has bits [15:13] = 3'b001, bits [6:5] = 2'b10, bit 7 = polarity, bit 4 = relative, and bits [2:0] = index, using the R3 mapping. It stalls while the target flag differs from the polarity. A wait on another source, encoded in bits [6:5], neither stalls nor changes any flag.
- R7: When a wait with polarity one completes, its flag is cleared at the next edge. A completing wait with polarity zero leaves the flags unchanged.
- R8: If machines set and clear the same flag in one cycle, the set wins. A host_clr_i bit wins over any set of that flag in the same cycle.
- R9: The raw interrupt source vector is {rx_not_empty_i[3:0], tx_not_full_i[3:0], flags[3:0]}, with bit 0 being flag 0. irq_o[k] is the OR of that vector ANDed with line_en_i[k*12 +: 12]. The output is combinational.
- R10: Flags 4 to 7 have no effect on irq_o.
- R11: flags_o shows the current flags. Each host_clr_i bit that is one clears its flag at the next edge, and zero bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| exec_valid_i | input | 4 | Per-machine instruction valid |
| exec_instr_i | input | 64 | Per-machine instruction, machine m in bits [m*16 +: 16] |
| exec_stall_o | output | 4 | Per-machine stall |
| host_clr_i | input | 8 | Host write-one-to-clear pulses |
| flags_o | output | 8 | Current flag bank |
| tx_not_full_i | input | 4 | Per-machine transmit FIFO not full |
| rx_not_empty_i | input | 4 | Per-machine receive FIFO not empty |
| line_en_i | input | 24 | Enable masks, line k in bits [k*12 +: 12] |
| irq_o | output | 2 | Interrupt lines |

## Verification
Directed cases first apply single raises with absolute and with relative indices on different machines. Comparing the bits that result separates the rotation rule from the plain index and shows that bit 2 is kept. Same-cycle raise/clear and raise/host-clear pairs show which side wins each conflict. Scripted raise-and-wait and wait-for-high or wait-for-low sequences show exactly which cycle releases the stall and whether the flag is consumed. After that, thousands of seeded random cycles mix every instruction kind, ignored opcodes, idle machines, host clears and enable masks. Machines that stall hold their instruction, so conflicts and long waits occur naturally, and a reference model follows the flags, stalls and lines in every cycle.

// File: rtl/irq_flag_pkg.sv
`timescale 1ns/1ps
package irq_flag_pkg;
  localparam int INSTR_W = 16;
  localparam logic [2:0] OP_WAIT = 3'd1;
  localparam logic [2:0] OP_FLAG = 3'd6;
  localparam logic [1:0] WSRC_FLAG = 2'd2;

  typedef struct packed {
    logic       is_flag;
    logic       is_wait;
    logic       clr;
    logic       hold;
    logic       pol;
    logic       rel;
    logic [2:0] idx;
  } flag_op_t;

  function automatic flag_op_t decode_op(input logic valid, input logic [INSTR_W-1:0] instr);
    flag_op_t op;
    op.is_flag = valid && (instr[15:13] == OP_FLAG);
    op.is_wait = valid && (instr[15:13] == OP_WAIT) && (instr[6:5] == WSRC_FLAG);
    op.clr     = instr[6];
    op.hold    = instr[5];
    op.pol     = instr[7];
    op.rel     = instr[4];
    op.idx     = instr[2:0];
    return op;
  endfunction
endpackage

// File: rtl/irq_req_unit.sv
`timescale 1ns/1ps
module irq_req_unit
  import irq_flag_pkg::*;
#(
  parameter int NUM_SM    = 4,
  parameter int NUM_FLAGS = 8,
  parameter int SM_ID     = 0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [INSTR_W-1:0]   instr_i,
  input  logic [NUM_FLAGS-1:0] flags_i,
  output logic [NUM_FLAGS-1:0] set_o,
  output logic [NUM_FLAGS-1:0] clr_o,
  output logic                 stall_o
);
  localparam int IDX_W = $clog2(NUM_FLAGS);
  localparam logic [IDX_W-1:0] GRP_MASK = IDX_W'(NUM_SM - 1);
  localparam logic [IDX_W-1:0] SM_OFS   = IDX_W'(SM_ID);

  flag_op_t       op;
  logic [IDX_W-1:0] idx, eff;
  logic           flag_bit;
  logic           raised_q, raised_d;

  assign op  = decode_op(valid_i, instr_i);
  assign idx = op.idx[IDX_W-1:0];
  // relative: rotate low bits within the group, keep the group bits
  assign eff = op.rel ? ((idx & ~GRP_MASK) | ((idx + SM_OFS) & GRP_MASK)) : idx;
  assign flag_bit = flags_i[eff];

  always_comb begin
    set_o    = '0;
    clr_o    = '0;
    stall_o  = 1'b0;
    raised_d = 1'b0;
    if (op.is_flag) begin
      if (op.clr) begin
        clr_o[eff] = 1'b1;
      end else if (op.hold) begin
        if (!raised_q) begin
          set_o[eff] = 1'b1;
          stall_o    = 1'b1;
          raised_d   = 1'b1;
        end else begin
          stall_o  = flag_bit;
          raised_d = flag_bit;
        end
      end else begin
        set_o[eff] = 1'b1;
      end
    end else if (op.is_wait) begin
      stall_o = (flag_bit != op.pol);
      if ((flag_bit == op.pol) && op.pol) clr_o[eff] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raised_q <= 1'b0;
    else         raised_q <= raised_d;
  end

  assert_hold_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raised_q && op.is_flag && op.hold && !op.clr && !flags_i[eff]) |-> !stall_o);

  assert_wait_match_free_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op.is_wait && (flags_i[eff] == op.pol)) |-> !stall_o);

  assert_clear_nostall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op.is_flag && op.clr) |-> !stall_o);
endmodule

// File: rtl/irq_flag_bank.sv
`timescale 1ns/1ps
module irq_flag_bank #(
  parameter int NUM_SM    = 4,
  parameter int NUM_FLAGS = 8
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_SM-1:0][NUM_FLAGS-1:0]  set_i,
  input  logic [NUM_SM-1:0][NUM_FLAGS-1:0]  clr_i,
  input  logic [NUM_FLAGS-1:0]              host_clr_i,
  output logic [NUM_FLAGS-1:0]              flags_o
);
  logic [NUM_FLAGS-1:0] set_any, clr_any, flags_q, flags_d;

  always_comb begin
    set_any = '0;
    clr_any = '0;
    for (int s = 0; s < NUM_SM; s++) begin
      set_any |= set_i[s];
      clr_any |= clr_i[s];
    end
    // machine set beats machine clear; host clear beats everything
    flags_d = ((flags_q & ~clr_any) | set_any) & ~host_clr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : gen_chk
    assert_host_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      host_clr_i[g] |=> !flags_q[g]);
    assert_set_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_any[g] && !host_clr_i[g]) |=> flags_q[g]);
    assert_quiet_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!set_any[g] && !clr_any[g] && !host_clr_i[g]) |=> (flags_q[g] == $past(flags_q[g])));
  end
endmodule

// File: rtl/irq_line_mux.sv
`timescale 1ns/1ps
module irq_line_mux #(
  parameter int NUM_SM    = 4,
  parameter int NUM_LINES = 2,
  parameter int SRC_W     = 3 * NUM_SM
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_SM-1:0]           flags_i,
  input  logic [NUM_SM-1:0]           tx_not_full_i,
  input  logic [NUM_SM-1:0]           rx_not_empty_i,
  input  logic [NUM_LINES*SRC_W-1:0]  line_en_i,
  output logic [NUM_LINES-1:0]        irq_o
);
  logic [SRC_W-1:0] raw;
  assign raw = {rx_not_empty_i, tx_not_full_i, flags_i};

  for (genvar k = 0; k < NUM_LINES; k++) begin : gen_line
    assign irq_o[k] = |(raw & line_en_i[k*SRC_W +: SRC_W]);

    assert_masked_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (line_en_i[k*SRC_W +: SRC_W] == '0) |-> !irq_o[k]);
  end
endmodule

// File: rtl/irq_flag_ctrl.sv
`timescale 1ns/1ps
module irq_flag_ctrl
  import irq_flag_pkg::*;
#(
  parameter int NUM_SM    = 4,
  parameter int NUM_FLAGS = 8,
  parameter int NUM_LINES = 2,
  localparam int SRC_W    = 3 * NUM_SM
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_SM-1:0]             exec_valid_i,
  input  logic [NUM_SM*INSTR_W-1:0]     exec_instr_i,
  output logic [NUM_SM-1:0]             exec_stall_o,
  input  logic [NUM_FLAGS-1:0]          host_clr_i,
  output logic [NUM_FLAGS-1:0]          flags_o,
  input  logic [NUM_SM-1:0]             tx_not_full_i,
  input  logic [NUM_SM-1:0]             rx_not_empty_i,
  input  logic [NUM_LINES*SRC_W-1:0]    line_en_i,
  output logic [NUM_LINES-1:0]          irq_o
);
  logic [NUM_SM-1:0][NUM_FLAGS-1:0] sm_set, sm_clr;
  logic [NUM_FLAGS-1:0]             flags;

  for (genvar s = 0; s < NUM_SM; s++) begin : gen_unit
    irq_req_unit #(
      .NUM_SM   (NUM_SM),
      .NUM_FLAGS(NUM_FLAGS),
      .SM_ID    (s)
    ) u_unit (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .valid_i(exec_valid_i[s]),
      .instr_i(exec_instr_i[s*INSTR_W +: INSTR_W]),
      .flags_i(flags),
      .set_o  (sm_set[s]),
      .clr_o  (sm_clr[s]),
      .stall_o(exec_stall_o[s])
    );
  end

  irq_flag_bank #(
    .NUM_SM   (NUM_SM),
    .NUM_FLAGS(NUM_FLAGS)
  ) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (sm_set),
    .clr_i     (sm_clr),
    .host_clr_i(host_clr_i),
    .flags_o   (flags)
  );

  irq_line_mux #(
    .NUM_SM   (NUM_SM),
    .NUM_LINES(NUM_LINES),
    .SRC_W    (SRC_W)
  ) u_lines (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .flags_i       (flags[NUM_SM-1:0]),
    .tx_not_full_i (tx_not_full_i),
    .rx_not_empty_i(rx_not_empty_i),
    .line_en_i     (line_en_i),
    .irq_o         (irq_o)
  );

  assign flags_o = flags;

  assert_upper_unrouted_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(tx_not_full_i) && $stable(rx_not_empty_i) && $stable(line_en_i) &&
     $stable(flags[NUM_SM-1:0])) |-> $stable(irq_o));
endmodule

// File: tb/irq_flag_ctrl_bench.sv
`timescale 1ns/1ps
module irq_flag_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  exec_valid = '0;
  logic [63:0] exec_instr = '0;
  logic [3:0]  exec_stall;
  logic [7:0]  host_clr = '0;
  logic [7:0]  flags;
  logic [3:0]  tx_nf = '0, rx_ne = '0;
  logic [23:0] line_en = '0;
  logic [1:0]  irq;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  irq_flag_ctrl u_irq_flag_ctrl (
    .clk_i(clk), .rst_ni(rst_ni),
    .exec_valid_i(exec_valid), .exec_instr_i(exec_instr), .exec_stall_o(exec_stall),
    .host_clr_i(host_clr), .flags_o(flags),
    .tx_not_full_i(tx_nf), .rx_not_empty_i(rx_ne),
    .line_en_i(line_en), .irq_o(irq)
  );

  always #10 clk = ~clk;

  // model state
  logic [7:0] m_flags = '0, nxt_flags;
  logic [3:0] m_raised = '0, nxt_raised, exp_stall;
  logic [1:0] exp_irq;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] eff_idx(logic [15:0] ins, int sm);
    logic [2:0] i;
    i = ins[2:0];
    if (ins[4]) return {i[2], 2'(i[1:0] + 2'(sm))};
    return i;
  endfunction

  task automatic model_eval();
    logic [7:0] set_m, clr_m;
    logic [11:0] raw;
    set_m = '0; clr_m = '0;
    for (int s = 0; s < 4; s++) begin
      logic [15:0] ins;
      logic [2:0] e;
      ins = exec_instr[s*16 +: 16];
      e = eff_idx(ins, s);
      exp_stall[s] = 1'b0;
      nxt_raised[s] = 1'b0;
      if (exec_valid[s] && ins[15:13] == 3'd6) begin
        if (ins[6]) clr_m[e] = 1'b1;
        else if (ins[5]) begin
          if (!m_raised[s]) begin
            set_m[e] = 1'b1; exp_stall[s] = 1'b1; nxt_raised[s] = 1'b1;
          end else begin
            exp_stall[s] = m_flags[e]; nxt_raised[s] = m_flags[e];
          end
        end else set_m[e] = 1'b1;
      end else if (exec_valid[s] && ins[15:13] == 3'd1 && ins[6:5] == 2'd2) begin
        exp_stall[s] = (m_flags[e] != ins[7]);
        if (!exp_stall[s] && ins[7]) clr_m[e] = 1'b1;
      end
    end
    nxt_flags = ((m_flags & ~clr_m) | set_m) & ~host_clr;
    raw = {rx_ne, tx_nf, m_flags[3:0]};
    for (int k = 0; k < 2; k++) exp_irq[k] = |(raw & line_en[k*12 +: 12]);
  endtask

  // called at a negedge with drives set; returns at the next negedge
  task automatic cycle(string tag);
    model_eval();
    #2;
    check({tag, " flags"}, 32'(flags), 32'(m_flags));
    check({tag, " stall"}, 32'(exec_stall), 32'(exp_stall));
    check({tag, " irq"}, 32'(irq), 32'(exp_irq));
    @(posedge clk);
    m_flags = nxt_flags;
    m_raised = nxt_raised;
    @(negedge clk);
  endtask

  task automatic drive(int s, logic v, logic [15:0] ins);
    exec_valid[s] = v;
    exec_instr[s*16 +: 16] = ins;
  endtask

  task automatic idle();
    exec_valid = '0; exec_instr = '0; host_clr = '0;
  endtask

  function automatic logic [15:0] rand_instr();
    logic [15:0] r;
    r = 16'($urandom);
    case ($urandom % 8)
      0, 7: return {3'd6, 5'($urandom), 1'b0, 2'b00, r[4], 1'b0, r[2:0]};
      1:    return {3'd6, 5'($urandom), 1'b0, 2'b10, r[4], 1'b0, r[2:0]};
      2:    return {3'd6, 5'($urandom), 1'b0, 2'b01, r[4], 1'b0, r[2:0]};
      3, 4: return {3'd1, 5'($urandom), r[7], 2'b10, r[4], 1'b0, r[2:0]};
      5:    return {3'd3, r[12:0]};
      default: return {3'd1, 5'($urandom), r[7], 2'b00, r[4:0]};
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 reset flags", 32'(flags), 0);
    check("R1 reset stall", 32'(exec_stall), 0);
    check("R1 reset irq", 32'(irq), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 after release flags", 32'(flags), 0);

    // R2 absolute raise
    drive(0, 1, 16'hC002); cycle("R2");
    idle(); check("R2 raise idx2", 32'(flags), 32'h04);

    // R3 relative: sm1 idx3 -> 0, sm3 idx6 -> 5
    drive(1, 1, 16'hC013); drive(3, 1, 16'hC016); cycle("R3");
    idle(); check("R3 relative map", 32'(flags), 32'h25);

    // R9 line composition
    line_en = {12'hF00, 12'h00F}; #1;
    check("R9 lines", 32'(irq), 32'b01);
    @(negedge clk);

    // R4 clear
    drive(2, 1, 16'hC042); cycle("R4");
    idle(); check("R4 clear idx2", 32'(flags), 32'h21);

    // R8 set vs clear, host clear vs set
    drive(0, 1, 16'hC001); drive(1, 1, 16'hC041); cycle("R8");
    idle(); check("R8 set beats clear", 32'(flags), 32'h23);
    drive(0, 1, 16'hC001); host_clr = 8'h02; cycle("R8");
    idle(); check("R8 host beats set", 32'(flags), 32'h21);

    // R11 host clear
    host_clr = 8'h01; cycle("R11");
    idle(); check("R11 host w1c", 32'(flags), 32'h20);
    host_clr = 8'h10; cycle("R11");
    idle(); check("R11 zero bits keep", 32'(flags), 32'h20);

    // R10 upper flags unrouted, R9 FIFO sources
    line_en = {12'h000, 12'hFFF}; #1;
    check("R10 flag5 not routed", 32'(irq), 0);
    @(negedge clk);
    tx_nf = 4'b0100; line_en = {12'h040, 12'h000}; #1;
    check("R9 tx source", 32'(irq), 32'b10);
    @(negedge clk);
    rx_ne = 4'b0001; line_en = {12'h040, 12'h100}; #1;
    check("R9 rx source", 32'(irq), 32'b11);
    @(negedge clk);
    tx_nf = '0; rx_ne = '0; line_en = '0;

    // R5 raise with wait
    drive(2, 1, 16'hC023); #1;
    check("R5 issue stall", 32'(exec_stall[2]), 1);
    cycle("R5");
    #1; check("R5 held stall", 32'(exec_stall[2]), 1);
    cycle("R5");
    host_clr = 8'h08; #1;
    check("R5 still stalled", 32'(exec_stall[2]), 1);
    cycle("R5");
    host_clr = '0; #1;
    check("R5 released", 32'(exec_stall[2]), 0);
    cycle("R5");
    idle();

    // R6 and R7: wait high on flag 6
    drive(0, 1, 16'h20C6); #1;
    check("R6 wait high stalls", 32'(exec_stall[0]), 1);
    cycle("R6");
    drive(1, 1, 16'hC006); cycle("R6");
    drive(1, 0, 16'h0000); #1;
    check("R7 wait high done", 32'(exec_stall[0]), 0);
    cycle("R7");
    idle(); check("R7 flag consumed", 32'(flags), 32'h20);

    // wait low on flag 5
    drive(0, 1, 16'h2045); #1;
    check("R6 wait low stalls", 32'(exec_stall[0]), 1);
    cycle("R6");
    host_clr = 8'h20; cycle("R6");
    host_clr = '0; #1;
    check("R7 wait low done", 32'(exec_stall[0]), 0);
    cycle("R7");
    idle(); check("R7 wait low no change", 32'(flags), 0);

    // R2 ignored instructions, R6 other wait source
    drive(3, 1, 16'hE003); drive(0, 0, 16'hC007); drive(1, 1, 16'h2087); #1;
    check("R6 gpio wait no stall", 32'(exec_stall[1]), 0);
    cycle("R2");
    idle(); check("R2 ignored", 32'(flags), 0);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      for (int s = 0; s < 4; s++) begin
        if (!exp_stall[s]) drive(s, ($urandom % 5) != 0, rand_instr());
      end
      host_clr = (($urandom % 4) == 0) ? 8'($urandom) : 8'h00;
      tx_nf = 4'($urandom); rx_ne = 4'($urandom);
      if (($urandom % 16) == 0) line_en = 24'($urandom);
      cycle("R8 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule